// File: doc/BRIEF.md
# Prefetch Ring with Out-of-Order Completion Tracking

This block is an on-chip ring of packet slots that holds local copies of command packets fetched from a host queue. Three free-running indices move around the ring. The write index claims slots for copies that are on their way in. The dispatch index hands filled packets downstream in order. The read index retires slots once their packets have finished. A slot's state follows from where it lies relative to these indices. Between write and dispatch it is allocated, with its copy possibly still pending. Between dispatch and read it is submitted, dispatched but not yet retired. Everywhere else it is free.

Each slot stores the packet header and the host address that the packet was copied from. Each slot also has a completion bit, because packets may finish in any order. An external copy engine does the following through the block's ports: it allocates slots, writes headers, and records the host addresses of a run of packets. A consumer takes packets through a valid/ready handshake and reports each finished packet by its slot number. A retire request frees the longest run of finished packets at the head of the ring. The block also reports three values. The first is the free slot count. The second is the number of packets awaiting completion. The third is a flag that is set when the oldest unfinished packet is the only one still outstanding. A barrier can use this flag to release itself.

Top module: `prq_ring`

## Requirements
- R1: After reset, `free_cnt` is DEPTH (16), `cmpl_pend` is 0, `disp_valid` is 0 and `last_out` is 0.
- R2: A request for n slots is granted in the same cycle only when 1 <= n <= `free_cnt`. A grant advances the write index by n, so `free_cnt` drops by n in the next cycle. A refused request changes nothing.
- R3: Every slot claimed by a grant gets a header whose type field, bits [7:0], holds the invalid code 1. `disp_valid` is 1 only when the dispatch index is behind the write index and the slot at the dispatch index has a type field other than 1.
- R4: A header write stores `hdr_val` into slot `hdr_slot`. In the same cycle it takes priority over the invalid marking of a grant. `disp_hdr` shows the stored header of the slot at the dispatch index.
- R5: An address record of n packets at slot s with base B stores B + 64*k into slot (s + k) mod 16 for k = 0..n-1. `disp_addr` shows the stored address of the slot at the dispatch index.
- R6: When `disp_valid` and `disp_ready` are both 1 at a clock edge, the dispatch index advances by one. `disp_slot` is the dispatch index mod 16.
- R7: `cmpl_pend` equals the dispatch index minus the read index.
- R8: A completion sets the bit of `cmpl_slot` only if that slot lies between the read index (inclusive) and the dispatch index (exclusive). A completion for any other slot is ignored.
- R9: `last_out` is 1 exactly when three things hold: the read index differs from the dispatch index, the slot at the read index is not complete, and every later slot before the dispatch index is complete.
- R10: A retire request advances the read index past the longest run of completed slots that starts at the read index, stopping at the dispatch index. It clears those bits, so `free_cnt` rises by the run length in the next cycle.
- R11: Indices run freely and a slot number is its index mod 16. `alloc_slot` is the write index mod 16, and allocation, dispatch and retirement continue correctly across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request to claim slots |
| alloc_num | input | 5 | Number of slots requested |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_slot | output | 4 | Slot of the first claimed entry |
| hdr_we | input | 1 | Header write strobe |
| hdr_slot | input | 4 | Slot for the header write |
| hdr_val | input | 16 | Header value |
| addr_we | input | 1 | Host address record strobe |
| addr_slot | input | 4 | First slot of the recorded run |
| addr_num | input | 5 | Packets in the recorded run |
| addr_base | input | 32 | Host address of the first packet |
| disp_valid | output | 1 | A packet is ready to dispatch |
| disp_ready | input | 1 | Consumer accepts the packet |
| disp_slot | output | 4 | Slot at the dispatch index |
| disp_hdr | output | 16 | Header of that slot |
| disp_addr | output | 32 | Host address of that slot |
| cmpl_valid | input | 1 | Completion report strobe |
| cmpl_slot | input | 4 | Slot that finished |
| retire_req | input | 1 | Retire finished head entries |
| free_cnt | output | 5 | Free slots |
| cmpl_pend | output | 5 | Dispatched packets not yet retired |
| last_out | output | 1 | Oldest unfinished packet is the only outstanding one |

## Verification
A stray completion bit shows up the next cycle in `last_out`, and it also shows up as an early jump in `free_cnt` when the following retire frees too many slots. A wrong index shows up at once in `cmpl_pend`, `free_cnt` and `disp_slot`. A lost invalid mark or a wrongly placed address shows up the cycle that slot reaches the dispatch index, as a `disp_valid` that is set too early or a wrong `disp_addr`. Stimulus runs far past the index wrap, with completions arriving out of order and sometimes aimed at slots outside the submitted range, so each of these faults reaches a port within a few cycles.

// File: rtl/prq_pkg.sv
package prq_pkg;
    localparam int         PKT_BYTES    = 64;
    localparam int         TYPE_W       = 8;
    localparam logic [7:0] TYPE_INVALID = 8'd1;
endpackage

// File: rtl/prq_slot_store.sv
module prq_slot_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int HDR_W  = 16,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [SLOT_W-1:0] alloc_slot,
    input  logic [CNT_W-1:0]  alloc_num,
    input  logic              hdr_we,
    input  logic [SLOT_W-1:0] hdr_slot,
    input  logic [HDR_W-1:0]  hdr_val,
    input  logic              addr_we,
    input  logic [SLOT_W-1:0] addr_slot,
    input  logic [CNT_W-1:0]  addr_num,
    input  logic [ADDR_W-1:0] addr_base,
    input  logic [SLOT_W-1:0] look_slot,
    output logic [HDR_W-1:0]  look_hdr,
    output logic [ADDR_W-1:0] look_addr
);
    import prq_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][HDR_W-1:0]  hdr;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [SLOT_W-1:0] ofs(input int s, input logic [SLOT_W-1:0] b);
        return SLOT_W'(s) - b;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < DEPTH; s++) begin
            if (alloc_fire && ({1'b0, ofs(s, alloc_slot)} < alloc_num))
                st_d.hdr[s] = {{(HDR_W-TYPE_W){1'b0}}, TYPE_INVALID};
            if (addr_we && ({1'b0, ofs(s, addr_slot)} < addr_num))
                st_d.addr[s] = addr_base + ADDR_W'(PKT_BYTES * int'(ofs(s, addr_slot)));
        end
        if (hdr_we)
            st_d.hdr[hdr_slot] = hdr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign look_hdr  = st_q.hdr[look_slot];
    assign look_addr = st_q.addr[look_slot];

    // R3
    alloc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire && !(hdr_we && hdr_slot == alloc_slot)
        |=> st_q.hdr[$past(alloc_slot)][TYPE_W-1:0] == TYPE_INVALID);

    // R5
    addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we && addr_num != '0 |=> st_q.addr[$past(addr_slot)] == $past(addr_base));
endmodule

// File: rtl/prq_cmpl_track.sv
module prq_cmpl_track #(
    parameter int DEPTH = 16,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [CNT_W-1:0]  pend_cnt,
    input  logic              cmpl_valid,
    input  logic [SLOT_W-1:0] cmpl_slot,
    input  logic              retire_req,
    output logic [CNT_W-1:0]  retire_num,
    output logic              last_out
);
    logic [DEPTH-1:0]  done_d, done_q;
    logic [SLOT_W-1:0] cmpl_ofs;
    logic [CNT_W-1:0]  run_len;
    logic              run_on, tail_done;

    function automatic logic [SLOT_W-1:0] slot_at(input logic [SLOT_W-1:0] b, input int i);
        return b + SLOT_W'(i);
    endfunction

    assign cmpl_ofs = cmpl_slot - rd_slot;

    always_comb begin
        run_on    = 1'b1;
        run_len   = '0;
        tail_done = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < pend_cnt) begin
                if (run_on && done_q[slot_at(rd_slot, i)]) run_len = run_len + 1'b1;
                else                                       run_on  = 1'b0;
                if (i != 0 && !done_q[slot_at(rd_slot, i)]) tail_done = 1'b0;
            end
        end
    end

    assign retire_num = retire_req ? run_len : '0;
    assign last_out   = (pend_cnt != '0) && !done_q[rd_slot] && tail_done;

    always_comb begin
        done_d = done_q;
        if (cmpl_valid && ({1'b0, cmpl_ofs} < pend_cnt))
            done_d[cmpl_slot] = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            if (CNT_W'(i) < retire_num) done_d[slot_at(rd_slot, i)] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= done_d;
    end

    // R8
    stray_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid && ({1'b0, cmpl_ofs} >= pend_cnt) && !done_q[cmpl_slot]
        |=> !done_q[$past(cmpl_slot)]);

    // R10
    retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_num != '0 |=> !done_q[$past(rd_slot)]);

    // R10
    retire_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_num <= pend_cnt);
endmodule

// File: rtl/prq_ring.sv
module prq_ring #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int HDR_W  = 16,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [CNT_W-1:0]  alloc_num,
    output logic              alloc_gnt,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              hdr_we,
    input  logic [SLOT_W-1:0] hdr_slot,
    input  logic [HDR_W-1:0]  hdr_val,
    input  logic              addr_we,
    input  logic [SLOT_W-1:0] addr_slot,
    input  logic [CNT_W-1:0]  addr_num,
    input  logic [ADDR_W-1:0] addr_base,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [SLOT_W-1:0] disp_slot,
    output logic [HDR_W-1:0]  disp_hdr,
    output logic [ADDR_W-1:0] disp_addr,
    input  logic              cmpl_valid,
    input  logic [SLOT_W-1:0] cmpl_slot,
    input  logic              retire_req,
    output logic [CNT_W-1:0]  free_cnt,
    output logic [CNT_W-1:0]  cmpl_pend,
    output logic              last_out
);
    import prq_pkg::*;

    localparam int IDX_W = CNT_W;

    typedef struct packed {
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] dp;
        logic [IDX_W-1:0] rd;
    } idx_t;

    idx_t             idx_d, idx_q;
    logic [CNT_W-1:0] occ, retire_num;
    logic             disp_fire;

    assign occ        = idx_q.wr - idx_q.rd;
    assign free_cnt   = CNT_W'(DEPTH) - occ;
    assign cmpl_pend  = idx_q.dp - idx_q.rd;
    assign alloc_gnt  = alloc_req && (alloc_num != '0) && (alloc_num <= free_cnt);
    assign alloc_slot = idx_q.wr[SLOT_W-1:0];
    assign disp_slot  = idx_q.dp[SLOT_W-1:0];
    assign disp_valid = (idx_q.dp != idx_q.wr) && (disp_hdr[TYPE_W-1:0] != TYPE_INVALID);
    assign disp_fire  = disp_valid && disp_ready;

    always_comb begin
        idx_d = idx_q;
        if (alloc_gnt) idx_d.wr = idx_q.wr + alloc_num;
        if (disp_fire) idx_d.dp = idx_q.dp + 1'b1;
        idx_d.rd = idx_q.rd + retire_num;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    prq_slot_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HDR_W(HDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_gnt),
        .alloc_slot (alloc_slot),
        .alloc_num  (alloc_num),
        .hdr_we     (hdr_we),
        .hdr_slot   (hdr_slot),
        .hdr_val    (hdr_val),
        .addr_we    (addr_we),
        .addr_slot  (addr_slot),
        .addr_num   (addr_num),
        .addr_base  (addr_base),
        .look_slot  (disp_slot),
        .look_hdr   (disp_hdr),
        .look_addr  (disp_addr)
    );

    prq_cmpl_track #(.DEPTH(DEPTH)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_slot    (idx_q.rd[SLOT_W-1:0]),
        .pend_cnt   (cmpl_pend),
        .cmpl_valid (cmpl_valid),
        .cmpl_slot  (cmpl_slot),
        .retire_req (retire_req),
        .retire_num (retire_num),
        .last_out   (last_out)
    );

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> idx_q.wr == $past(idx_q.wr) + $past(alloc_num));

    // R6
    disp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready |=> idx_q.dp == $past(idx_q.dp) + 1'b1);

    // R7
    disp_behind_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_pend <= occ);
endmodule

// File: tb/prq_ring_tb.sv
module prq_ring_tb;
    localparam int D  = 16;
    localparam int AW = 32;
    localparam int HW = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          alloc_req = 0, hdr_we = 0, addr_we = 0, disp_ready = 0, cmpl_valid = 0, retire_req = 0;
    logic [4:0]    alloc_num = 0, addr_num = 0;
    logic [3:0]    hdr_slot = 0, addr_slot = 0, cmpl_slot = 0;
    logic [HW-1:0] hdr_val = 0;
    logic [AW-1:0] addr_base = 0;
    logic          alloc_gnt, disp_valid, last_out;
    logic [3:0]    alloc_slot, disp_slot;
    logic [HW-1:0] disp_hdr;
    logic [AW-1:0] disp_addr;
    logic [4:0]    free_cnt, cmpl_pend;

    int vectors = 0, miscompares = 0;
    int m_wr = 0, m_dp = 0, m_rd = 0;
    logic [HW-1:0] m_hdr [D];
    logic [AW-1:0] m_addr[D];
    bit            m_done[D];

    always #2 clk = ~clk;

    prq_ring u_dut (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int a_req, input int a_num, input int h_we, input int h_slot,
                        input int h_val, input int ad_we, input int ad_slot, input int ad_num,
                        input longint ad_base, input int d_rdy, input int c_v, input int c_slot,
                        input int r_req);
        int occ, pend, ds, run, e_gnt, e_dv, e_last;
        bit on;
        alloc_req = 1'(a_req); alloc_num = 5'(a_num);
        hdr_we = 1'(h_we); hdr_slot = 4'(h_slot); hdr_val = HW'(h_val);
        addr_we = 1'(ad_we); addr_slot = 4'(ad_slot); addr_num = 5'(ad_num); addr_base = AW'(ad_base);
        disp_ready = 1'(d_rdy); cmpl_valid = 1'(c_v); cmpl_slot = 4'(c_slot); retire_req = 1'(r_req);
        #1;
        occ  = m_wr - m_rd;
        pend = m_dp - m_rd;
        ds   = m_dp % D;
        e_gnt = (a_req != 0 && a_num != 0 && a_num <= D - occ) ? 1 : 0;
        e_dv  = (m_dp != m_wr && m_hdr[ds][7:0] != 8'd1) ? 1 : 0;
        e_last = (pend != 0 && !m_done[m_rd % D]) ? 1 : 0;
        for (int i = 1; i < pend; i++) if (!m_done[(m_rd + i) % D]) e_last = 0;
        chk("R2 alloc_gnt", alloc_gnt, e_gnt);
        chk("R11 alloc_slot", alloc_slot, m_wr % D);
        chk("R10 free_cnt", free_cnt, D - occ);
        chk("R7 cmpl_pend", cmpl_pend, pend);
        chk("R9 last_out", last_out, e_last);
        chk("R3 disp_valid", disp_valid, e_dv);
        chk("R6 disp_slot", disp_slot, ds);
        chk("R4 disp_hdr", disp_hdr, m_hdr[ds]);
        chk("R5 disp_addr", disp_addr, m_addr[ds]);
        run = 0; on = 1;
        for (int i = 0; i < pend; i++) begin
            if (on && m_done[(m_rd + i) % D]) run++;
            else on = 0;
        end
        if (e_gnt != 0) begin
            for (int k = 0; k < a_num; k++) m_hdr[(m_wr + k) % D] = 16'h0001;
            m_wr += a_num;
        end
        if (h_we != 0) m_hdr[h_slot] = HW'(h_val);
        if (ad_we != 0)
            for (int k = 0; k < ad_num; k++) m_addr[(ad_slot + k) % D] = AW'(ad_base + 64 * k);
        if (e_dv != 0 && d_rdy != 0) m_dp++;
        if (c_v != 0 && ((c_slot - (m_rd % D) + D) % D) < pend) m_done[c_slot] = 1;
        if (r_req != 0) begin
            for (int i = 0; i < run; i++) m_done[(m_rd + i) % D] = 0;
            m_rd += run;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int s = 0; s < D; s++) begin m_hdr[s] = '0; m_addr[s] = '0; m_done[s] = 0; end
        @(negedge clk); @(negedge clk);
        chk("R1 free_cnt", free_cnt, D);
        chk("R1 cmpl_pend", cmpl_pend, 0);
        chk("R1 disp_valid", disp_valid, 0);
        chk("R1 last_out", last_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: oversize request refused, then two slots claimed
        step(1, 17, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 2, 0, 0, 0, 1, 0, 2, 64'h1000, 0, 0, 0, 0);
        step(0, 0, 1, 0, 16'h0A02, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 16'h0B03, 0, 0, 0, 0, 1, 0, 0, 0);
        // R8: slot 1 is not yet dispatched, so this report is ignored
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        idle();
        chk("R8 stray completion ignored", last_out, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
        idle();
        chk("R9 only head outstanding", last_out, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        idle();
        chk("R10 ring drained", free_cnt, D);
        for (int n = 0; n < 6000; n++) begin
            int hs, cs, hv, pend;
            hs = (m_wr != m_dp) ? (m_dp + int'($urandom % (m_wr - m_dp))) % D : int'($urandom % D);
            hv = int'({$urandom % 256, (($urandom % 5) == 0) ? 8'd1 : 8'(2 + $urandom % 200)});
            pend = m_dp - m_rd;
            cs = (pend > 0 && ($urandom % 4) != 0) ? (m_rd + int'($urandom % pend)) % D
                                                   : int'($urandom % D);
            step(($urandom % 3) == 0, int'($urandom % 6),
                 int'($urandom % 2), hs, hv,
                 ($urandom % 4) == 0, int'($urandom % D), int'($urandom % 17), longint'($urandom),
                 int'($urandom % 2), int'($urandom % 2), cs, ($urandom % 3) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule